// File: doc/BRIEF.md
# Multi-slot TDM serial audio receiver

This block receives frame-synchronous serial audio. A stream of bits on one or more data pins is sampled when a bit-rate strobe is high. The stream is cut into frames, and each frame is cut into time slots. A frame marker sampled high opens a frame. Each slot carries one sample word per pin, sent most significant bit first. When the last bit of a slot has been sampled, the assembled words from all pins are presented together with the slot's index.

The number of slots per frame and the slot width are set at run time. A per-slot enable mask suppresses the valid strobe for unwanted slots, but those slots still take their place in the frame timing. A long-frame mode fixes the frame at 384 slots, so the end-of-frame event falls on the block boundaries of a consumer digital audio link. A frame marker that arrives before the frame has run its full length is reported, and the frame count restarts from that marker.

Top module: `tdm_slot_receiver`

## Requirements
- R1: After reset, every output is 0. No slot event occurs until a strobed sample has the frame marker high, and data sampled before that is ignored.
- R2: The sample taken with the frame marker high is the MSB of slot 0 on every pin. The slot index then advances after each slot-width bits, and slots run continuously from frame to frame.
- R3: The slot width is `cfg_width`, clamped to the range 8..32 (for example, 3 acts as 8). Each word is right-aligned in its 32-bit field, with the upper bits zero.
- R4: The number of slots per frame is `cfg_slots`, clamped to the range 2..32 (for example, 0 acts as 2).
- R5: `rx_valid` is raised for slot s only if `slot_mask` bit (s mod 32) is 1. A slot whose bit is 0 still gives `slot_pulse` and still advances the slot index.
- R6: `slot_pulse` is high for exactly one clock, in the clock after the strobed sample that completes a slot. `rx_slot` gives that slot's index in the same clock.
- R7: `last_slot_pulse` rises together with `slot_pulse`, and only for the final slot of a frame.
- R8: With `cfg_long` set, a frame is 384 slots, so `last_slot_pulse` marks slot 383 whatever the value of `cfg_slots`.
- R9: A frame marker that arrives while a frame is still running gives a one-clock `sync_err` pulse and restarts at slot 0. A marker that arrives exactly when the previous frame has ended gives no error.
- R10: All pins share the same slot timing. The word from pin p appears in `rx_data[p*32 +: 32]`.
- R11: `rx_data` changes only in a clock where `rx_valid` is high, and `rx_valid` is only ever high together with `slot_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | High for one clock at each serial bit time |
| fsync | input | 1 | Frame marker, sampled when bit_tick is high |
| sdata | input | NUM_PINS | Serial data pins |
| cfg_slots | input | 6 | Slots per frame, 2..32 |
| cfg_width | input | 6 | Bits per slot, 8..32 |
| cfg_long | input | 1 | Selects 384-slot frames |
| slot_mask | input | 32 | Enable bit for each slot (index mod 32) |
| rx_valid | output | 1 | Captured word is valid |
| rx_slot | output | 9 | Index of the slot just finished |
| rx_data | output | NUM_PINS*32 | Words from all pins, pin 0 in the low field |
| slot_pulse | output | 1 | Slot-finished event |
| last_slot_pulse | output | 1 | Final-slot-of-frame event |
| sync_err | output | 1 | Frame marker arrived early |

## Verification
Some properties are checked on every clock. A valid word or an end-of-frame event never appears without a slot event. A valid word always matches an enabled mask bit. The data field does not change without a valid word. After the last slot the counters return to zero, and after an early marker they restart at the first bit of slot 0. Other behaviour can only be shown by the bench scenarios: that the words match the serial bits MSB-first on each pin, that the slot and width settings are clamped, that the 384-slot frame ends on slot 383, and that back-to-back frames raise no error while a truncated frame does.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
package tdm_rx_pkg;
  // Clamp a requested setting into [lo, hi].
  function automatic int clamp_int(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Index of the final slot of a frame for the given settings.
  function automatic int final_slot(input int req_slots, input bit long_mode,
                                    input int lo, input int hi, input int long_n);
    if (long_mode) return long_n - 1;
    return clamp_int(req_slots, lo, hi) - 1;
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
`timescale 1ns/1ps
module tdm_slot_timer #(
  parameter int WORD_W     = 32,
  parameter int MAX_SLOTS  = 32,
  parameter int LONG_SLOTS = 384,
  parameter int MIN_WIDTH  = 8,
  parameter int MIN_SLOTS  = 2,
  localparam int CNT_W  = $clog2(WORD_W),
  localparam int CFG_W  = $clog2(WORD_W) + 1,
  localparam int CS_W   = $clog2(MAX_SLOTS) + 1,
  localparam int SLOT_W = $clog2(LONG_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic [CS_W-1:0]   cfg_slots,
  input  logic [CFG_W-1:0]  cfg_width,
  input  logic              cfg_long,
  output logic              shift_en,
  output logic              first_bit,
  output logic              word_end,
  output logic              frame_end,
  output logic              sync_bad,
  output logic [SLOT_W-1:0] cur_slot
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic              locked;
  logic [CNT_W-1:0]  idx_bit;
  logic [CFG_W-1:0]  eff_w;
  logic [SLOT_W-1:0] last_idx;

  always_comb begin
    eff_w    = CFG_W'(tdm_rx_pkg::clamp_int(int'(cfg_width), MIN_WIDTH, WORD_W));
    last_idx = SLOT_W'(tdm_rx_pkg::final_slot(int'(cfg_slots), cfg_long,
                                              MIN_SLOTS, MAX_SLOTS, LONG_SLOTS));
    shift_en  = bit_tick && (fsync || locked);
    idx_bit   = fsync ? '0 : bit_cnt;
    cur_slot  = fsync ? '0 : slot_cnt;
    first_bit = shift_en && (idx_bit == '0);
    word_end  = shift_en && (CFG_W'(idx_bit) >= eff_w - CFG_W'(1));
    frame_end = word_end && (cur_slot >= last_idx);
    sync_bad  = bit_tick && fsync && locked &&
                !((bit_cnt == '0) && (slot_cnt == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      slot_cnt <= '0;
      locked   <= 1'b0;
    end else if (bit_tick) begin
      if (fsync) locked <= 1'b1;
      if (shift_en) begin
        if (word_end) begin
          bit_cnt  <= '0;
          slot_cnt <= frame_end ? '0 : cur_slot + SLOT_W'(1);
        end else begin
          bit_cnt  <= idx_bit + CNT_W'(1);
          slot_cnt <= cur_slot;
        end
      end
    end
  end

  // R9
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_bad |=> (bit_cnt == CNT_W'(1)) && (slot_cnt == '0));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_cnt == '0) && (slot_cnt == '0));
  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt < SLOT_W'(LONG_SLOTS));
  // R1
  idle_until_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (bit_cnt == '0) && (slot_cnt == '0));
endmodule

// File: rtl/tdm_lane_shifter.sv
`timescale 1ns/1ps
module tdm_lane_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              first_bit,
  input  logic              sdata_bit,
  output logic [WORD_W-1:0] word_next
);
  logic [WORD_W-2:0] sh;

  always_comb begin
    if (first_bit) word_next = WORD_W'(sdata_bit);
    else           word_next = {sh, sdata_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (shift_en) sh <= word_next[WORD_W-2:0];
  end

  // R2
  first_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_bit |-> shift_en);
endmodule

// File: rtl/tdm_slot_output.sv
`timescale 1ns/1ps
module tdm_slot_output #(
  parameter int NUM_PINS  = 2,
  parameter int WORD_W    = 32,
  parameter int MAX_SLOTS = 32,
  parameter int SLOT_W    = 9,
  localparam int MI_W   = $clog2(MAX_SLOTS),
  localparam int DATA_W = NUM_PINS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_end,
  input  logic                 frame_end,
  input  logic                 sync_bad,
  input  logic [SLOT_W-1:0]    cur_slot,
  input  logic [DATA_W-1:0]    lane_words,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  output logic                 rx_valid,
  output logic [SLOT_W-1:0]    rx_slot,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 slot_pulse,
  output logic                 last_slot_pulse,
  output logic                 sync_err
);
  logic slot_on;
  assign slot_on = slot_mask[cur_slot[MI_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid        <= 1'b0;
      rx_slot         <= '0;
      rx_data         <= '0;
      slot_pulse      <= 1'b0;
      last_slot_pulse <= 1'b0;
      sync_err        <= 1'b0;
    end else begin
      slot_pulse      <= word_end;
      last_slot_pulse <= frame_end;
      rx_valid        <= word_end && slot_on;
      sync_err        <= sync_bad;
      if (word_end) rx_slot <= cur_slot;
      if (word_end && slot_on) rx_data <= lane_words;
    end
  end

  // R11
  valid_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> slot_pulse);
  // R7
  last_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot_pulse |-> slot_pulse);
  // R5
  mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (($past(slot_mask) & (MAX_SLOTS'(1) << rx_slot[MI_W-1:0])) != '0));
  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_pulse |=> !slot_pulse);
endmodule

// File: rtl/tdm_slot_receiver.sv
`timescale 1ns/1ps
module tdm_slot_receiver #(
  parameter int NUM_PINS   = 2,
  parameter int WORD_W     = 32,
  parameter int MAX_SLOTS  = 32,
  parameter int LONG_SLOTS = 384,
  parameter int MIN_WIDTH  = 8,
  parameter int MIN_SLOTS  = 2,
  localparam int CFG_W  = $clog2(WORD_W) + 1,
  localparam int CS_W   = $clog2(MAX_SLOTS) + 1,
  localparam int SLOT_W = $clog2(LONG_SLOTS),
  localparam int DATA_W = NUM_PINS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 fsync,
  input  logic [NUM_PINS-1:0]  sdata,
  input  logic [CS_W-1:0]      cfg_slots,
  input  logic [CFG_W-1:0]     cfg_width,
  input  logic                 cfg_long,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  output logic                 rx_valid,
  output logic [SLOT_W-1:0]    rx_slot,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 slot_pulse,
  output logic                 last_slot_pulse,
  output logic                 sync_err
);
  // Internal events, named for the assertions.
  logic              ev_shift;
  logic              ev_first;
  logic              ev_word_end;
  logic              ev_frame_end;
  logic              ev_sync_bad;
  logic [SLOT_W-1:0] ev_slot;
  logic [DATA_W-1:0] lane_words;

  tdm_slot_timer #(
    .WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS), .LONG_SLOTS(LONG_SLOTS),
    .MIN_WIDTH(MIN_WIDTH), .MIN_SLOTS(MIN_SLOTS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .cfg_slots(cfg_slots), .cfg_width(cfg_width), .cfg_long(cfg_long),
    .shift_en(ev_shift), .first_bit(ev_first), .word_end(ev_word_end),
    .frame_end(ev_frame_end), .sync_bad(ev_sync_bad), .cur_slot(ev_slot)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    tdm_lane_shifter #(.WORD_W(WORD_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift_en(ev_shift), .first_bit(ev_first),
      .sdata_bit(sdata[p]), .word_next(lane_words[p*WORD_W +: WORD_W])
    );
  end

  tdm_slot_output #(
    .NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .word_end(ev_word_end), .frame_end(ev_frame_end),
    .sync_bad(ev_sync_bad), .cur_slot(ev_slot), .lane_words(lane_words),
    .slot_mask(slot_mask), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_data(rx_data), .slot_pulse(slot_pulse),
    .last_slot_pulse(last_slot_pulse), .sync_err(sync_err)
  );

  // R7
  frame_end_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |-> ev_word_end);
  // R9
  sync_err_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync_bad |=> sync_err);
endmodule

// File: tb/tb_tdm_slot_receiver.sv
`timescale 1ns/1ps
module tb_tdm_slot_receiver;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        fsync = 1'b0;
  logic [NP-1:0] sdata = '0;
  logic [5:0]  cfg_slots = 6'd8;
  logic [5:0]  cfg_width = 6'd16;
  logic        cfg_long = 1'b0;
  logic [31:0] slot_mask = '1;
  logic        rx_valid, slot_pulse, last_slot_pulse, sync_err;
  logic [8:0]  rx_slot;
  logic [NP*32-1:0] rx_data;

  tdm_slot_receiver #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync), .sdata(sdata),
    .cfg_slots(cfg_slots), .cfg_width(cfg_width), .cfg_long(cfg_long),
    .slot_mask(slot_mask), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_data(rx_data), .slot_pulse(slot_pulse),
    .last_slot_pulse(last_slot_pulse), .sync_err(sync_err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // Monitor log
  logic [8:0]       cap_slot [0:511];
  logic [NP*32-1:0] cap_data [0:511];
  int cap_n = 0, n_pulse = 0, n_last = 0, n_serr = 0, n_hold = 0;
  logic [8:0] last_at = '0;
  logic [NP*32-1:0] prev_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && cap_n < 512) begin
        cap_slot[cap_n] = rx_slot;
        cap_data[cap_n] = rx_data;
        cap_n++;
      end
      if (slot_pulse) n_pulse++;
      if (last_slot_pulse) begin n_last++; last_at = rx_slot; end
      if (sync_err) n_serr++;
      if (!rx_valid && rx_data != prev_data) n_hold++;
    end
    prev_data = rx_data;
  end

  task automatic clear_log();
    cap_n = 0; n_pulse = 0; n_last = 0; n_serr = 0; n_hold = 0; last_at = '0;
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int p, int s, int f, int w);
    logic [31:0] v;
    v = (32'h9E37_79B9 * (s + 3)) ^ (32'h0101_0101 * (p + 1)) ^ (32'(f) << 11);
    if (w < 32) v = v & ((32'd1 << w) - 32'd1);
    return v;
  endfunction

  task automatic drive_bit(bit fs, logic [NP-1:0] b);
    @(negedge clk);
    fsync = fs; sdata = b; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; fsync = 1'b0;
  endtask

  // Sends slots [0, nsend) of a frame laid out with width w.
  task automatic send_frame(int nsend, int w, int f);
    for (int s = 0; s < nsend; s++)
      for (int b = 0; b < w; b++) begin
        logic [NP-1:0] bits;
        for (int p = 0; p < NP; p++) bits[p] = pat(p, s, f, w)[w-1-b];
        drive_bit(s == 0 && b == 0, bits);
      end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Compare captured words [k0..] with expected enabled slots.
  task automatic verify_words(string req, int k0, int nslots, int w, int f,
                              logic [31:0] mask);
    int k = k0;
    for (int s = 0; s < nslots; s++) begin
      if (mask[s % 32]) begin
        check(req, $sformatf("slot index at capture %0d", k), cap_slot[k], s);
        for (int p = 0; p < NP; p++)
          check("R10", $sformatf("pin %0d slot %0d word", p, s),
                cap_data[k][p*32 +: 32], pat(p, s, f, w));
        k++;
      end
    end
  endtask

  task automatic t_reset();
    check("R1", "outputs after reset",
          {rx_valid, slot_pulse, last_slot_pulse, sync_err, rx_slot}, 0);
    check("R1", "data after reset", rx_data, 0);
    clear_log();
    for (int i = 0; i < 40; i++) drive_bit(1'b0, NP'(i));
    settle();
    check("R1", "no slot events before frame marker", n_pulse, 0);
  endtask

  task automatic t_basic();
    cfg_slots = 6'd8; cfg_width = 6'd16; cfg_long = 1'b0; slot_mask = '1;
    clear_log();
    send_frame(8, 16, 0);
    send_frame(8, 16, 1);
    settle();
    check("R6", "slot pulses over two frames", n_pulse, 16);
    check("R7", "last-slot pulses", n_last, 2);
    check("R7", "last-slot index", last_at, 7);
    check("R9", "no error on back-to-back frames", n_serr, 0);
    check("R2", "words captured", cap_n, 16);
    verify_words("R2", 0, 8, 16, 0, '1);
    verify_words("R3", 8, 8, 16, 1, '1);
    check("R11", "data changed without valid", n_hold, 0);
  endtask

  task automatic t_mask();
    cfg_slots = 6'd4; cfg_width = 6'd24; slot_mask = 32'h5;
    clear_log();
    send_frame(4, 24, 2);
    settle();
    check("R5", "slot pulses incl. masked", n_pulse, 4);
    check("R5", "valid words", cap_n, 2);
    verify_words("R5", 0, 4, 24, 2, 32'h5);
    check("R11", "data held over masked slots", n_hold, 0);
  endtask

  task automatic t_limits();
    slot_mask = '1;
    cfg_slots = 6'd2; cfg_width = 6'd8;
    clear_log();
    send_frame(2, 8, 3);
    settle();
    check("R4", "two-slot frame last index", last_at, 1);
    verify_words("R3", 0, 2, 8, 3, '1);
    cfg_slots = 6'd32; cfg_width = 6'd32;
    clear_log();
    send_frame(32, 32, 4);
    settle();
    check("R4", "32-slot frame pulses", n_pulse, 32);
    check("R4", "32-slot frame last index", last_at, 31);
    verify_words("R3", 0, 32, 32, 4, '1);
  endtask

  task automatic t_clamp();
    cfg_slots = 6'd0; cfg_width = 6'd3; slot_mask = '1;
    clear_log();
    send_frame(2, 8, 5);
    settle();
    check("R4", "slot count 0 acts as 2", last_at, 1);
    check("R4", "clamped frame last pulses", n_last, 1);
    verify_words("R3", 0, 2, 8, 5, '1);
  endtask

  task automatic t_long();
    cfg_long = 1'b1; cfg_slots = 6'd8; cfg_width = 6'd8; slot_mask = 32'hFFFF_FFFE;
    clear_log();
    send_frame(384, 8, 6);
    settle();
    check("R8", "long frame slot pulses", n_pulse, 384);
    check("R8", "long frame last pulses", n_last, 1);
    check("R8", "long frame last index", last_at, 383);
    check("R5", "mask repeats every 32 slots", cap_n, 372);
    check("R8", "first valid slot", cap_slot[0], 1);
    check("R8", "final valid slot", cap_slot[371], 383);
    cfg_long = 1'b0;
  endtask

  task automatic t_sync();
    cfg_slots = 6'd8; cfg_width = 6'd8; slot_mask = '1;
    clear_log();
    send_frame(3, 8, 7);
    send_frame(8, 8, 8);
    settle();
    check("R9", "early marker error count", n_serr, 1);
    check("R9", "words after restart", cap_n, 11);
    check("R9", "restart slot index", cap_slot[3], 0);
    check("R9", "last pulses after restart", n_last, 1);
    verify_words("R9", 3, 8, 8, 8, '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_limits();
    t_clamp();
    t_long();
    t_sync();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule